// File: doc/BRIEF.md
# PCIe Root Port Interrupt Collector

This block gathers every interrupt-worthy condition seen by a PCIe root port bridge and presents it to the host CPU as a single level interrupt. Link, error, slave-side and master-side conditions arrive as one-cycle pulses on an event vector. Each pulse sets a sticky bit in a decode register. A mask register selects which decode bits may raise the interrupt line. Software clears decode bits by writing ones to them.

Legacy INTx and MSI messages arrive on one valid/ready stream and share one eight-entry queue. Error-message records arrive on a second valid/ready stream: correctable, non-fatal or fatal, each with a requester ID. They go into their own queue. The head of each queue is visible through read registers. Software removes the head entry by writing all ones to the head register. Both streams hold ready high whenever reset is released, so a source never stalls. A record offered while its queue is full is dropped, and the drop is latched in a sticky overflow flag that the next pop write clears.

The CPU port is a plain 32-bit register bus with write and read strobes and a 12-bit byte offset. Read data is combinational from the current offset, is zero while the read strobe is low, and has no side effects.

Top module: `pcie_rp_irq_collector`

## Requirements
- R1: After reset, the decode register (0x138) and the mask register (0x13C) read zero, both queues are empty, every head register reads zero, and irq_o is low.
- R2: A pulse on ev_pulse bit n sets decode bit n on the next clock, and the bit stays set. This applies to bits 0-3, 5-11 and 20-28. Pulses on bits 4, 12-19 and 29-31 have no effect on the decode register.
- R3: A write to 0x138 clears exactly the decode bits that are 1 in the written data. When a bit is set and cleared in the same cycle, the set wins.
- R4: The mask register at 0x13C is read/write over the valid source bits 0x1FF30FEF. A 1 enables that source. irq_o is high exactly when the decode register AND the mask register is nonzero.
- R5: The message head register at 0x158 reads as follows: bit 31 valid, bit 30 MSI flag, bit 29 assert, bits 28:27 INTx line, bits 26:16 MSI address, bit 15 overflow. Offset 0x15C gives the head's 16-bit MSI data in bits 15:0. With the queue empty, all fields except overflow read 0.
- R6: Writing 0xFFFFFFFF to 0x158 removes the head entry, or does nothing if the queue is empty. Any other value written there leaves the queue unchanged.
- R7: An accepted error record pushes its requester ID into the error queue. The kind code 0, 1 or 2 sets decode bit 9, 10 or 11; code 3 sets no decode bit. The head register at 0x154 shows valid at bit 18, the ID at bits 15:0 and overflow at bit 19.
- R8: Writing 0xFFFFFFFF to 0x154 removes the error queue head entry. Any other value written there has no effect.
- R9: Each queue holds 8 entries. A push into a full queue is dropped and sets that queue's sticky overflow flag. The flag is cleared by a pop write (all ones) to that head register; a drop in the same cycle wins over the clear.
- R10: An accepted message sets decode bit 16 (INTx) or bit 17 (MSI). While the message queue is non-empty, the bit matching the head entry's type is set again every cycle, so clearing it has no lasting effect.
- R11: The two MSI base address words at 0x14C and 0x150 are plain 32-bit read/write registers that reset to zero.
- R12: msg_ready and err_ready are high whenever rst_n is high. Each cycle with valid high accepts one record.
- R13: reg_rdata is zero whenever reg_rd is low. Unmapped offsets read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_pulse | input | 32 | One-cycle event pulses, one per decode bit |
| err_valid | input | 1 | Error record offered |
| err_ready | output | 1 | Error record accepted (high out of reset) |
| err_kind | input | 2 | 0 correctable, 1 non-fatal, 2 fatal, 3 record only |
| err_req_id | input | 16 | Requester ID of the error record |
| msg_valid | input | 1 | INTx/MSI message offered |
| msg_ready | output | 1 | Message accepted (high out of reset) |
| msg_is_msi | input | 1 | 1 for MSI, 0 for INTx |
| msg_assert | input | 1 | INTx assert (1) or deassert (0) |
| msg_line | input | 2 | INTx line number 0 to 3 |
| msg_addr | input | 11 | MSI address bits |
| msg_data | input | 16 | MSI message data |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data |
| irq_o | output | 1 | Combined interrupt |

## Verification
The assertions assume every input is known after reset, that valid is only judged while ready is high, and that event pulses and register strobes are sampled once per clock with no meaning given to their width beyond one cycle. The stimulus drives all inputs from the first cycle, changes them only shortly after a rising edge, and uses only the error kind codes and field widths listed above. Directed phases cover each queue filling past its depth, pop writes with and without all ones, and a push and a pop in the same cycle. A long mixed phase then overlaps all of these with decode clears.

// File: rtl/pcie_irq_pkg.sv
package pcie_irq_pkg;
  localparam int REG_AW = 12;

  localparam logic [REG_AW-1:0] OFS_DECODE  = 12'h138;
  localparam logic [REG_AW-1:0] OFS_MASK    = 12'h13C;
  localparam logic [REG_AW-1:0] OFS_MSIB_HI = 12'h14C;
  localparam logic [REG_AW-1:0] OFS_MSIB_LO = 12'h150;
  localparam logic [REG_AW-1:0] OFS_ERRQ    = 12'h154;
  localparam logic [REG_AW-1:0] OFS_MSGQ    = 12'h158;
  localparam logic [REG_AW-1:0] OFS_MSGDATA = 12'h15C;

  localparam int BIT_INTX = 16;
  localparam int BIT_MSI  = 17;
  localparam int BIT_CORR = 9;

  localparam logic [31:0] SRC_VALID   = 32'h1FF3_0FEF;
  localparam logic [31:0] PULSE_VALID = SRC_VALID & ~(32'h3 << BIT_INTX);

  typedef struct packed {
    logic        is_msi;
    logic        asrt;
    logic [1:0]  line;
    logic [10:0] addr;
    logic [15:0] data;
  } msg_rec_t;
endpackage

// File: rtl/irq_fifo.sv
module irq_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic         pop,
  input  logic         ovf_clr,
  input  logic [W-1:0] din,
  output logic [W-1:0] head,
  output logic         empty,
  output logic         full,
  output logic         ovf
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] rd_p, wr_p;
  logic [CW-1:0] cnt;
  logic          take, drop;

  assign empty = (cnt == '0);
  assign full  = (cnt == CW'(DEPTH));
  assign take  = push && !full;
  assign drop  = pop && !empty;
  assign head  = mem[rd_p];

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (take) mem[wr_p] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_p <= '0;
      wr_p <= '0;
      cnt  <= '0;
      ovf  <= 1'b0;
    end else begin
      if (take) wr_p <= bump(wr_p);
      if (drop) rd_p <= bump(rd_p);
      cnt <= cnt + CW'(take) - CW'(drop);
      if (push && full) ovf <= 1'b1;
      else if (ovf_clr) ovf <= 1'b0;
    end
  end

  // R9
  drop_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop) |=> ($stable(cnt) && ovf));

  // R6
  pop_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !empty && !push) |=> (cnt == $past(cnt) - 1'b1));

  // R9
  push_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !full && !pop) |=> (cnt == $past(cnt) + 1'b1));
endmodule

// File: rtl/irq_decode.sv
module irq_decode #(
  parameter int          DW    = 32,
  parameter logic [DW-1:0] VALID = '1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] set_vec,
  input  logic [DW-1:0] clr_vec,
  input  logic          mask_we,
  input  logic [DW-1:0] mask_din,
  output logic [DW-1:0] dec_q,
  output logic [DW-1:0] mask_q,
  output logic          irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_q  <= '0;
      mask_q <= '0;
    end else begin
      dec_q <= ((dec_q & ~clr_vec) | set_vec) & VALID;
      if (mask_we) mask_q <= mask_din & VALID;
    end
  end

  assign irq = |(dec_q & mask_q);

  // R3
  w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr_vec & ~set_vec)) |=> ((dec_q & $past(clr_vec & ~set_vec)) == '0));

  // R2
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_vec == '0) |=> ((dec_q & $past(dec_q)) == $past(dec_q)));

  // R4
  irq_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(mask_we || (|set_vec)));
endmodule

// File: rtl/pcie_rp_irq_collector.sv
module pcie_rp_irq_collector
  import pcie_irq_pkg::*;
#(
  parameter int QDEPTH = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] ev_pulse,
  input  logic        err_valid,
  output logic        err_ready,
  input  logic [1:0]  err_kind,
  input  logic [15:0] err_req_id,
  input  logic        msg_valid,
  output logic        msg_ready,
  input  logic        msg_is_msi,
  input  logic        msg_assert,
  input  logic [1:0]  msg_line,
  input  logic [10:0] msg_addr,
  input  logic [15:0] msg_data,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [11:0] reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        irq_o
);
  localparam int MSG_W   = $bits(msg_rec_t);
  localparam int NKIND   = 3;
  localparam int NBASE   = 2;

  logic [31:0]      dec_q, mask_q, set_vec, clr_vec, rd_mux;
  logic             mask_we;
  msg_rec_t         mq_in, mq_head;
  logic [MSG_W-1:0] mq_head_raw;
  logic             mq_push, mq_popw, mq_empty, mq_full, mq_ovf;
  logic [15:0]      eq_head;
  logic             eq_push, eq_popw, eq_empty, eq_full, eq_ovf;
  logic [NKIND-1:0] kind_hot;
  logic [31:0]      base_word [NBASE];

  assign msg_ready = rst_n;
  assign err_ready = rst_n;
  assign mq_push   = msg_valid && msg_ready;
  assign eq_push   = err_valid && err_ready;

  assign mq_popw = reg_wr && (reg_addr == OFS_MSGQ) && (reg_wdata == 32'hFFFF_FFFF);
  assign eq_popw = reg_wr && (reg_addr == OFS_ERRQ) && (reg_wdata == 32'hFFFF_FFFF);
  assign clr_vec = (reg_wr && (reg_addr == OFS_DECODE)) ? reg_wdata : '0;
  assign mask_we = reg_wr && (reg_addr == OFS_MASK);

  assign mq_in = '{is_msi: msg_is_msi, asrt: msg_assert, line: msg_line,
                   addr: msg_addr, data: msg_data};
  assign mq_head = msg_rec_t'(mq_head_raw);

  for (genvar k = 0; k < NKIND; k++) begin : g_kind
    assign kind_hot[k] = eq_push && (err_kind == 2'(k));
  end

  always_comb begin
    set_vec = ev_pulse & PULSE_VALID;
    set_vec[BIT_CORR +: NKIND] = set_vec[BIT_CORR +: NKIND] | kind_hot;
    if (mq_push)   set_vec[msg_is_msi ? BIT_MSI : BIT_INTX] = 1'b1;
    if (!mq_empty) set_vec[mq_head.is_msi ? BIT_MSI : BIT_INTX] = 1'b1;
  end

  irq_fifo #(.W(MSG_W), .DEPTH(QDEPTH)) u_msgq (
    .clk(clk), .rst_n(rst_n), .push(mq_push), .pop(mq_popw), .ovf_clr(mq_popw),
    .din(mq_in), .head(mq_head_raw), .empty(mq_empty), .full(mq_full), .ovf(mq_ovf)
  );

  irq_fifo #(.W(16), .DEPTH(QDEPTH)) u_errq (
    .clk(clk), .rst_n(rst_n), .push(eq_push), .pop(eq_popw), .ovf_clr(eq_popw),
    .din(err_req_id), .head(eq_head), .empty(eq_empty), .full(eq_full), .ovf(eq_ovf)
  );

  irq_decode #(.DW(32), .VALID(SRC_VALID)) u_dec (
    .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .clr_vec(clr_vec),
    .mask_we(mask_we), .mask_din(reg_wdata), .dec_q(dec_q), .mask_q(mask_q),
    .irq(irq_o)
  );

  for (genvar b = 0; b < NBASE; b++) begin : g_base
    localparam logic [11:0] OFS = (b == 0) ? OFS_MSIB_HI : OFS_MSIB_LO;
    logic [31:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else if (reg_wr && (reg_addr == OFS)) q <= reg_wdata;
    end
    assign base_word[b] = q;
  end

  always_comb begin
    case (reg_addr)
      OFS_DECODE:  rd_mux = dec_q;
      OFS_MASK:    rd_mux = mask_q;
      OFS_MSIB_HI: rd_mux = base_word[0];
      OFS_MSIB_LO: rd_mux = base_word[1];
      OFS_ERRQ:    rd_mux = {12'b0, eq_ovf, !eq_empty, 2'b0,
                             eq_empty ? 16'h0 : eq_head};
      OFS_MSGQ:    rd_mux = mq_empty ? {16'b0, mq_ovf, 15'b0}
                          : {1'b1, mq_head.is_msi, mq_head.asrt, mq_head.line,
                             mq_head.addr, mq_ovf, 15'b0};
      OFS_MSGDATA: rd_mux = {16'b0, mq_empty ? 16'h0 : mq_head.data};
      default:     rd_mux = '0;
    endcase
  end

  assign reg_rdata = reg_rd ? rd_mux : '0;

  // R10
  intx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mq_empty && !mq_head.is_msi) |=> dec_q[BIT_INTX]);

  // R10
  msi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mq_empty && mq_head.is_msi) |=> dec_q[BIT_MSI]);

  // R7
  fatal_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eq_push && (err_kind == 2'd2)) |=> dec_q[BIT_CORR + 2]);

  // R5
  empty_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && (reg_addr == OFS_MSGQ) && mq_empty) |-> !reg_rdata[31]);
endmodule

// File: tb/sim_pcie_rp_irq_collector.sv
`timescale 1ns/1ps
module sim_pcie_rp_irq_collector;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] ev_pulse;
  logic        err_valid, err_ready;
  logic [1:0]  err_kind;
  logic [15:0] err_req_id;
  logic        msg_valid, msg_ready, msg_is_msi, msg_assert;
  logic [1:0]  msg_line;
  logic [10:0] msg_addr;
  logic [15:0] msg_data;
  logic        reg_wr, reg_rd;
  logic [11:0] reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        irq_o;

  always #4 clk = ~clk;

  pcie_rp_irq_collector u0 (
    .clk(clk), .rst_n(rst_n), .ev_pulse(ev_pulse),
    .err_valid(err_valid), .err_ready(err_ready), .err_kind(err_kind),
    .err_req_id(err_req_id), .msg_valid(msg_valid), .msg_ready(msg_ready),
    .msg_is_msi(msg_is_msi), .msg_assert(msg_assert), .msg_line(msg_line),
    .msg_addr(msg_addr), .msg_data(msg_data), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_o(irq_o)
  );

  int    checks = 0;
  int    fails  = 0;
  bit    done   = 0;
  string cur_req = "R1";

  // reference model state
  logic [31:0] m_dec, m_mask, m_base_hi, m_base_lo;
  bit          m_movf, m_eovf;
  logic [30:0] mq[$];
  logic [15:0] eq[$];
  logic [31:0] m_set, m_clr;
  bit          m_mfull, m_efull, m_mpop, m_epop;

  localparam logic [31:0] VALID_BITS = 32'h1FF3_0FEF;
  localparam logic [31:0] PULSE_BITS = 32'h1FF0_0FEF;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_dec = 0; m_mask = 0; m_base_hi = 0; m_base_lo = 0;
      m_movf = 0; m_eovf = 0; mq.delete(); eq.delete();
    end else begin
      m_set = ev_pulse & PULSE_BITS;
      if (err_valid && err_kind != 2'd3) m_set[9 + err_kind] = 1'b1;
      if (msg_valid) m_set[msg_is_msi ? 17 : 16] = 1'b1;
      if (mq.size() > 0) m_set[mq[0][30] ? 17 : 16] = 1'b1;
      m_clr = (reg_wr && reg_addr == 12'h138) ? reg_wdata : 32'h0;
      if (reg_wr && reg_addr == 12'h13C) m_mask = reg_wdata & VALID_BITS;
      if (reg_wr && reg_addr == 12'h14C) m_base_hi = reg_wdata;
      if (reg_wr && reg_addr == 12'h150) m_base_lo = reg_wdata;
      m_mfull = mq.size() >= 8;
      m_efull = eq.size() >= 8;
      m_mpop = reg_wr && reg_addr == 12'h158 && reg_wdata == 32'hFFFF_FFFF;
      m_epop = reg_wr && reg_addr == 12'h154 && reg_wdata == 32'hFFFF_FFFF;
      if (m_mpop && mq.size() > 0) void'(mq.pop_front());
      if (m_epop && eq.size() > 0) void'(eq.pop_front());
      if (m_mpop) m_movf = 0;
      if (m_epop) m_eovf = 0;
      if (msg_valid) begin
        if (m_mfull) m_movf = 1;
        else mq.push_back({msg_is_msi, msg_assert, msg_line, msg_addr, msg_data});
      end
      if (err_valid) begin
        if (m_efull) m_eovf = 1;
        else eq.push_back(err_req_id);
      end
      m_dec = ((m_dec & ~m_clr) | m_set) & VALID_BITS;
    end
  end

  function automatic logic [31:0] exp_read(input logic [11:0] a, input logic rd);
    if (!rd) return 32'h0;
    case (a)
      12'h138: return m_dec;
      12'h13C: return m_mask;
      12'h14C: return m_base_hi;
      12'h150: return m_base_lo;
      12'h154: return {12'b0, m_eovf, eq.size() > 0, 2'b0,
                       (eq.size() > 0) ? eq[0] : 16'h0};
      12'h158: return (mq.size() > 0) ? {1'b1, mq[0][30:16], m_movf, 15'b0}
                                      : {16'b0, m_movf, 15'b0};
      12'h15C: return {16'b0, (mq.size() > 0) ? mq[0][15:0] : 16'h0};
      default: return 32'h0;
    endcase
  endfunction

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", cur_req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n === 1'b1 && !done) begin
      chk("reg_rdata", reg_rdata, exp_read(reg_addr, reg_rd));
      chk("irq_o", {31'b0, irq_o}, {31'b0, (m_dec & m_mask) != 0});
      chk("msg_ready R12", {31'b0, msg_ready}, 32'h1);
      chk("err_ready R12", {31'b0, err_ready}, 32'h1);
    end
  end

  task automatic step();
    @(posedge clk); #2;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1; step(); reg_wr = 1'b0;
  endtask

  task automatic look(input logic [11:0] a);
    reg_addr = a; step();
  endtask

  task automatic send_msg(input bit msi, input bit as, input logic [1:0] ln,
                          input logic [10:0] ad, input logic [15:0] dt);
    msg_valid = 1; msg_is_msi = msi; msg_assert = as; msg_line = ln;
    msg_addr = ad; msg_data = dt; step(); msg_valid = 0;
  endtask

  task automatic send_err(input logic [1:0] k, input logic [15:0] id);
    err_valid = 1; err_kind = k; err_req_id = id; step(); err_valid = 0;
  endtask

  task automatic pulse(input logic [31:0] v);
    ev_pulse = v; step(); ev_pulse = '0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired during %s", cur_req);
      finish_run();
    end
  end

  initial begin
    rst_n = 0; ev_pulse = '0; err_valid = 0; err_kind = 0; err_req_id = 0;
    msg_valid = 0; msg_is_msi = 0; msg_assert = 0; msg_line = 0; msg_addr = 0;
    msg_data = 0; reg_wr = 0; reg_rd = 1; reg_addr = 12'h138; reg_wdata = 0;
    repeat (4) @(posedge clk);
    #2 rst_n = 1;

    // R1 reset state of every register
    cur_req = "R1";
    look(12'h138); look(12'h13C); look(12'h154); look(12'h158); look(12'h15C);

    // R2 all-ones pulse, only defined bits stick
    cur_req = "R2";
    pulse(32'hFFFF_FFFF); look(12'h138); look(12'h138);
    wr(12'h138, 32'hFFFF_FFFF); look(12'h138);
    pulse(32'h0003_F010); look(12'h138);

    // R4 mask enables sources
    cur_req = "R4";
    wr(12'h13C, 32'hFFFF_FFFF); look(12'h13C);
    wr(12'h13C, 32'h0000_0002); pulse(32'h1); look(12'h138);
    pulse(32'h2); look(12'h138);
    wr(12'h13C, 32'h0); look(12'h138);
    wr(12'h13C, 32'h1FF3_0FEF);

    // R3 partial clear and set-wins
    cur_req = "R3";
    pulse(32'h1230_0F0F); look(12'h138);
    wr(12'h138, 32'h0030_000F); look(12'h138);
    ev_pulse = 32'h0000_0800; wr(12'h138, 32'h0000_0800); ev_pulse = '0; look(12'h138);
    wr(12'h138, 32'hFFFF_FFFF); look(12'h138);

    // R5 R10 message queue head fields and re-assertion
    cur_req = "R5";
    send_msg(0, 1, 2'd2, 11'h5A5, 16'h1234);
    look(12'h158); look(12'h15C);
    send_msg(1, 0, 2'd1, 11'h7FF, 16'hBEEF);
    look(12'h158);
    cur_req = "R10";
    wr(12'h138, 32'h0003_0000); look(12'h138); look(12'h138);

    // R6 pop only with all ones
    cur_req = "R6";
    wr(12'h158, 32'hFFFF_FFFE); look(12'h158);
    wr(12'h158, 32'hFFFF_FFFF); look(12'h158); look(12'h15C);
    wr(12'h138, 32'h0003_0000); look(12'h138);
    wr(12'h158, 32'hFFFF_FFFF); look(12'h158);
    wr(12'h138, 32'h0003_0000); look(12'h138);
    wr(12'h158, 32'hFFFF_FFFF); look(12'h158);

    // R7 error records and decode bits
    cur_req = "R7";
    send_err(2'd0, 16'hA001); look(12'h154); look(12'h138);
    send_err(2'd1, 16'hA002); send_err(2'd2, 16'hA003); send_err(2'd3, 16'hA004);
    look(12'h138); look(12'h154);

    // R8 error pops
    cur_req = "R8";
    wr(12'h154, 32'h0000_FFFF); look(12'h154);
    for (int i = 0; i < 5; i++) begin wr(12'h154, 32'hFFFF_FFFF); look(12'h154); end

    // R9 overflow on both queues
    cur_req = "R9";
    reg_addr = 12'h158;
    for (int i = 0; i < 10; i++) send_msg(i[0], 1, i[1:0], 11'(i), 16'(i * 7));
    look(12'h158);
    msg_valid = 1; wr(12'h158, 32'hFFFF_FFFF); msg_valid = 0; look(12'h158);
    wr(12'h158, 32'hFFFF_FFFF); look(12'h158);
    for (int i = 0; i < 9; i++) begin wr(12'h158, 32'hFFFF_FFFF); look(12'h15C); end
    reg_addr = 12'h154;
    for (int i = 0; i < 9; i++) send_err(2'd0, 16'(16'hC000 + i));
    look(12'h154);
    for (int i = 0; i < 9; i++) begin wr(12'h154, 32'hFFFF_FFFF); look(12'h154); end

    // R11 base words
    cur_req = "R11";
    wr(12'h14C, 32'h0000_0001); wr(12'h150, 32'hDEAD_0000);
    look(12'h14C); look(12'h150);

    // R13 read strobe gating and unmapped offsets
    cur_req = "R13";
    reg_rd = 0; look(12'h138); look(12'h150);
    reg_rd = 1; look(12'h000); look(12'h140);

    // R12 mixed traffic with everything overlapping
    cur_req = "R12";
    for (int i = 0; i < 600; i++) begin
      logic [11:0] offs [8];
      offs = '{12'h138, 12'h13C, 12'h14C, 12'h150, 12'h154, 12'h158, 12'h15C, 12'h100};
      ev_pulse   = $urandom & $urandom & $urandom;
      msg_valid  = ($urandom % 3) == 0;
      msg_is_msi = $urandom; msg_assert = $urandom; msg_line = $urandom;
      msg_addr   = $urandom; msg_data = $urandom;
      err_valid  = ($urandom % 4) == 0;
      err_kind   = $urandom; err_req_id = $urandom;
      reg_rd     = ($urandom % 8) != 0;
      reg_addr   = offs[$urandom % 8];
      reg_wr     = ($urandom % 3) == 0;
      reg_wdata  = (($urandom % 2) == 0) ? 32'hFFFF_FFFF : $urandom;
      step();
    end
    ev_pulse = '0; msg_valid = 0; err_valid = 0; reg_wr = 0; reg_rd = 1;
    look(12'h138); look(12'h158); look(12'h154);

    finish_run();
  end
endmodule